// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block collects event strobes from a USB function controller and keeps each one as a sticky interrupt flag that software can read. There are two flag registers and two matching enable registers, and all four share one register-select and write-data bus. The endpoint flag register holds these flags:

- transfer-request on the monitored IN endpoint, set when an IN token finds no valid transmit data;
- transmit-complete, set when a packet was sent and the host returned ACK;
- bus connect/disconnect, set on either edge of the synchronized VBUS sense input.

The power flag register holds these flags:

- suspend-detected;
- wake-detected, set on resume signalling or a bus reset;
- a live, read-only configuration-valid status bit.

The suspend-detected and wake-detected flags can only set while the controller is in suspend mode.

Software clears a flag by writing 0 to its bit. Writing 1 to a bit leaves that bit as it is. If an event arrives in the same cycle as a clear, the event wins. Each flag is ANDed with its enable bit, and the results are ORed into a registered interrupt request line.

Top module: `usb_irq_flags`

## Requirements
- R1: After reset these values hold: endpoint flags (sel 0) read 0x00, power flags (sel 1) read 0x20 when `cfg_valid_in` is 1, both enable registers (sel 2 and sel 3) read 0x00, and `irq` is 0.
- R2: A write to a flag register clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged.
- R3: An event strobe that arrives in the same cycle as a software clear of its flag leaves the flag set.
- R4: A one-cycle `ev_xfer_req` pulse sets bit 0 of sel 0, and a one-cycle `ev_tx_done` pulse sets bit 1 of sel 0. Each flag is readable after the clock edge that samples the pulse.
- R5: Each rising or falling edge of `vbus_raw` sets bit 2 of sel 0 at the (SYNC_STAGES+1)-th clock edge after the change, and not earlier.
- R6: `ev_suspend` sets bit 0 of sel 1 only while `suspend_mode` is 1. Otherwise it has no effect.
- R7: `ev_resume` or `ev_bus_reset` sets bit 1 of sel 1 only while `suspend_mode` is 1. Otherwise they have no effect.
- R8: Bit 5 of sel 1 shows `cfg_valid_in` one cycle late, and writes cannot change it. Bits 7:3 of sel 0 and bits 7:6 and 4:2 of sel 1 always read 0.
- R9: The enable registers at sel 2 (endpoint) and sel 3 (power) are plain 8-bit read/write registers. Bit n of each enables flag bit n of its flag register.
- R10: `irq` is 1 in the cycle after any flag is set together with its enable bit, and 0 in the cycle after no such pair exists. The configuration-valid bit never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `sel` |
| sel | input | 2 | Register select: 0 endpoint flags, 1 power flags, 2 endpoint enables, 3 power enables |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at `sel` (combinational) |
| ev_xfer_req | input | 1 | IN token found no valid transmit data |
| ev_tx_done | input | 1 | Packet sent and ACK received |
| vbus_raw | input | 1 | Asynchronous VBUS sense level |
| ev_suspend | input | 1 | Suspend signalling detected |
| ev_resume | input | 1 | Resume signalling detected |
| ev_bus_reset | input | 1 | Bus reset detected |
| suspend_mode | input | 1 | Controller is in suspend mode |
| cfg_valid_in | input | 1 | Live configuration-valid status |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that value, the VBUS edge latency of three clock edges can be checked cycle by cycle, and the bench checks that the flag is still clear one edge before it sets. A vector table covers the enable registers and the masking of flag registers. Directed sequences then cover the race between a set and a clear, the gating by suspend mode, and the one-cycle lag of `irq` after each flag or enable change.

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ev_xfer_req,
  input  logic       ev_tx_done,
  input  logic       vbus_raw,
  input  logic       ev_suspend,
  input  logic       ev_resume,
  input  logic       ev_bus_reset,
  input  logic       suspend_mode,
  input  logic       cfg_valid_in,
  output logic       irq
);
  localparam int EP_N = 3;
  localparam int PM_N = 2;
  localparam int CFG_BIT = 5;

  logic [SYNC_STAGES:0] vb_q;
  logic [EP_N-1:0] ep_flags, ep_set;
  logic [PM_N-1:0] pm_flags, pm_set;
  logic [7:0] en_ep, en_pm;
  logic cfg_q;
  logic vbus_edge;

  assign vbus_edge = vb_q[SYNC_STAGES] ^ vb_q[SYNC_STAGES-1];
  assign ep_set = {vbus_edge, ev_tx_done, ev_xfer_req};
  assign pm_set = {suspend_mode & (ev_resume | ev_bus_reset), suspend_mode & ev_suspend};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb_q     <= '0;
      ep_flags <= '0;
      pm_flags <= '0;
      en_ep    <= '0;
      en_pm    <= '0;
      cfg_q    <= 1'b1;
      irq      <= 1'b0;
    end else begin
      vb_q     <= {vb_q[SYNC_STAGES-1:0], vbus_raw};
      cfg_q    <= cfg_valid_in;
      ep_flags <= ((wr_en && sel == 2'd0) ? (ep_flags & wdata[EP_N-1:0]) : ep_flags) | ep_set;
      pm_flags <= ((wr_en && sel == 2'd1) ? (pm_flags & wdata[PM_N-1:0]) : pm_flags) | pm_set;
      if (wr_en && sel == 2'd2) en_ep <= wdata;
      if (wr_en && sel == 2'd3) en_pm <= wdata;
      irq <= |(ep_flags & en_ep[EP_N-1:0]) | |(pm_flags & en_pm[PM_N-1:0]);
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      2'd0: rdata[EP_N-1:0] = ep_flags;
      2'd1: begin
        rdata[PM_N-1:0] = pm_flags;
        rdata[CFG_BIT]  = cfg_q;
      end
      2'd2: rdata = en_ep;
      default: rdata = en_pm;
    endcase
  end
endmodule

// File: rtl/usb_irq_flags_chk.sv
module usb_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] sel,
  input logic [7:0] wdata,
  input logic       ev_xfer_req,
  input logic       ev_tx_done,
  input logic       ev_suspend,
  input logic       suspend_mode,
  input logic [2:0] ep_flags,
  input logic [1:0] pm_flags,
  input logic [7:0] en_ep,
  input logic [7:0] en_pm,
  input logic       irq
);
  logic src;
  assign src = |(ep_flags & en_ep[2:0]) | |(pm_flags & en_pm[1:0]);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0 && !wdata[0] && !ev_xfer_req) |=> !ep_flags[0]);
  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0 && wdata[1] && ep_flags[1]) |=> ep_flags[1]);
  p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_req |=> ep_flags[0]);
  p_txdone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> ep_flags[1]);
  p_susp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend_mode && !pm_flags[0]) |=> !pm_flags[0]);
  p_irq_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    src |=> irq);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !src |=> !irq);
endmodule

bind usb_irq_flags usb_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
  .ev_xfer_req(ev_xfer_req), .ev_tx_done(ev_tx_done), .ev_suspend(ev_suspend),
  .suspend_mode(suspend_mode), .ep_flags(ep_flags), .pm_flags(pm_flags),
  .en_ep(en_ep), .en_pm(en_pm), .irq(irq)
);

// File: tb/tb_usb_irq_flags.sv
module tb_usb_irq_flags;
  localparam int SYNC_STAGES = 2;
  localparam int NVEC = 10;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ev_xfer_req = 0, ev_tx_done = 0, vbus_raw = 0, ev_suspend = 0;
  logic ev_resume = 0, ev_bus_reset = 0, suspend_mode = 0, cfg_valid_in = 1;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usb_irq_flags #(.SYNC_STAGES(SYNC_STAGES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata), .rdata(rdata),
    .ev_xfer_req(ev_xfer_req), .ev_tx_done(ev_tx_done), .vbus_raw(vbus_raw),
    .ev_suspend(ev_suspend), .ev_resume(ev_resume), .ev_bus_reset(ev_bus_reset),
    .suspend_mode(suspend_mode), .cfg_valid_in(cfg_valid_in), .irq(irq)
  );

  typedef struct packed { logic [1:0] s; logic [7:0] d; logic [7:0] e; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 8'hA5, 8'hA5}, '{2'd3, 8'h3C, 8'h3C}, '{2'd2, 8'h00, 8'h00},
    '{2'd3, 8'hFF, 8'hFF}, '{2'd3, 8'h00, 8'h00}, '{2'd0, 8'hFF, 8'h00},
    '{2'd1, 8'hFF, 8'h20}, '{2'd1, 8'h00, 8'h20}, '{2'd2, 8'h5A, 8'h5A},
    '{2'd2, 8'h00, 8'h00}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    sel = s; wdata = d; wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic rd(string req, logic [1:0] s, logic [7:0] exp);
    sel = s; #1; chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1; #1;
    // R1 reset state
    rd("R1", 0, 8'h00); rd("R1", 1, 8'h20); rd("R1", 2, 8'h00); rd("R1", 3, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].s, VECS[i].d);
      rd(VECS[i].s >= 2 ? "R9" : "R8", VECS[i].s, VECS[i].e);
    end

    // R4 endpoint events
    ev_xfer_req = 1; step(); ev_xfer_req = 0;
    rd("R4", 0, 8'h01);
    ev_tx_done = 1; step(); ev_tx_done = 0;
    rd("R4", 0, 8'h03);
    // R2 write-zero-to-clear, write-one keeps
    wr(0, 8'hFE); rd("R2", 0, 8'h02);
    wr(0, 8'hFF); rd("R2", 0, 8'h02);
    // R3 event beats clear
    ev_xfer_req = 1; wr(0, 8'h00); ev_xfer_req = 0;
    rd("R3", 0, 8'h01);
    wr(0, 8'h00); rd("R2", 0, 8'h00);

    // R5 VBUS edges through the synchronizer
    vbus_raw = 1;
    repeat (SYNC_STAGES) step();
    rd("R5", 0, 8'h00);
    step(); rd("R5", 0, 8'h04);
    wr(0, 8'h00); rd("R5", 0, 8'h00);
    vbus_raw = 0;
    repeat (SYNC_STAGES) step();
    rd("R5", 0, 8'h00);
    step(); rd("R5", 0, 8'h04);
    wr(0, 8'h00);

    // R6 suspend flag gated by suspend mode
    ev_suspend = 1; step(); ev_suspend = 0;
    rd("R6", 1, 8'h20);
    suspend_mode = 1; ev_suspend = 1; step(); ev_suspend = 0;
    rd("R6", 1, 8'h21);
    // R7 wake flag
    suspend_mode = 0; ev_resume = 1; ev_bus_reset = 1; step(); ev_resume = 0; ev_bus_reset = 0;
    rd("R7", 1, 8'h21);
    suspend_mode = 1; ev_resume = 1; step(); ev_resume = 0;
    rd("R7", 1, 8'h23);
    wr(1, 8'hFD); rd("R7", 1, 8'h21);
    ev_bus_reset = 1; step(); ev_bus_reset = 0;
    rd("R7", 1, 8'h23);
    suspend_mode = 0;
    wr(1, 8'h00); rd("R2", 1, 8'h20);

    // R8 live config bit, not writable
    cfg_valid_in = 0; step(); rd("R8", 1, 8'h00);
    wr(1, 8'hFF); rd("R8", 1, 8'h00);
    cfg_valid_in = 1; step(); rd("R8", 1, 8'h20);

    // R10 registered interrupt
    wr(3, 8'h20); step(); step();
    chk("R10", {7'd0, irq}, 8'h00);
    ev_tx_done = 1; step(); ev_tx_done = 0;
    step(); chk("R10", {7'd0, irq}, 8'h00);
    wr(2, 8'h02); chk("R10", {7'd0, irq}, 8'h00);
    step(); chk("R10", {7'd0, irq}, 8'h01);
    wr(0, 8'hFD); chk("R10", {7'd0, irq}, 8'h01);
    step(); chk("R10", {7'd0, irq}, 8'h00);
    suspend_mode = 1; ev_suspend = 1; step(); ev_suspend = 0; suspend_mode = 0;
    wr(3, 8'h01); chk("R10", {7'd0, irq}, 8'h00);
    step(); chk("R10", {7'd0, irq}, 8'h01);
    wr(3, 8'h00); step(); chk("R10", {7'd0, irq}, 8'h00);

    finish_run();
  end
endmodule